// File: doc/BRIEF.md
# Serial Frame Parity Encoder and Cross-Checker

This block models both ends of an asynchronous serial link in one step. A character is packed into a frame word, least significant bit first, under a transmit line configuration: the data bits, then an optional parity bit, then one or two stop bits. The same frame word is then unpacked under a receive line configuration, which may differ from the transmit one. The result is a status word holding the recovered character, the receive configuration, and flags for parity and framing errors.

The block is used to show what a receiver would report when the two ends of a link disagree on word length, parity or stop bits. It also serves as a parity generator and checker when both configurations match. The block has no start bit and no bit timing. All logic between input and output is combinational, and the result is captured in one register stage. A valid strobe follows that register stage, and there is no back-pressure.

Top module: `frame_parity_xcheck`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_status` is 0.
- R2: `out_valid` is 1 exactly one clock after a cycle with `in_valid` high, and 0 otherwise; every input beat is accepted. When no result is produced, `out_status` keeps its last value.
- R3: A configuration byte uses bits [1:0] as the word-length code (data bits = 5 + code), bit 2 for two stop bits, bit 3 for parity enable, bit 4 for even parity (0 = odd), and bit 5 for stick parity. Bits 7:6 play no part in framing. The transmit side sends min(`in_nbits`, 5 + code) data bits, and data bits above that count are sent as 0.
- R4: With transmit parity enabled, the parity bit sits directly above the data bits. With stick parity it is 1. Otherwise it is the XOR of the sent data bits for even parity, and the inverse of that XOR for odd parity.
- R5: After the data bits and any parity bit, the transmitter places one stop bit of value 1, then a second stop bit of value 1 when two stop bits are selected. All higher frame positions are 0.
- R6: The receiver takes 5 + (receive code) data bits from the low end of the frame. Status bits 7 down to that count are 0.
- R7: With receive parity enabled, X is the XOR of the received data bits and the bit just above them. With stick parity, the parity error is set when that bit is 0. With even parity, it is set when X is 1. With odd parity, it is set when X is 0.
- R8: With receive parity disabled, the parity error is 0 and the first stop bit is read directly above the data bits.
- R9: The framing error is set when the first stop bit is 0. When the receive side selects two stop bits, it is also set when the second stop bit is 0.
- R10: The status word holds the data in bits 7:0, the full receive configuration byte (bits 7:6 included) in bits 15:8, the parity error in bit 16 and the framing error in bit 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat strobe |
| in_data | input | 8 | Character to frame |
| in_nbits | input | 4 | Requested number of data bits |
| tx_cfg | input | 8 | Transmit line configuration byte |
| rx_cfg | input | 8 | Receive line configuration byte |
| out_valid | output | 1 | Status word valid, one clock after `in_valid` |
| out_status | output | 18 | {framing error, parity error, rx config, data} |

## Verification
The parity check and the framing check can both fail in the same status word. This happens when a short transmit frame without parity is read by a receiver that expects more data bits, parity and two stop bits. The zero-filled upper frame positions then land on both the parity bit and the stop bits. The bench provokes this with hand-computed directed cases and with a sweep over every transmit configuration against many receive configurations. Beats are sent back to back, and each status word is compared against an independently computed expected value queued by the driver.

// File: rtl/frame_parity_xcheck.sv
module frame_parity_xcheck (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic [3:0]  in_nbits,
  input  logic [7:0]  tx_cfg,
  input  logic [7:0]  rx_cfg,
  output logic        out_valid,
  output logic [17:0] out_status
);
  localparam int DW = 8;
  localparam int FW = 12;

  logic [3:0]    tx_max, tx_w, rx_n, pos, q;
  logic [FW-1:0] frame;
  logic          tx_par, rx_x, pe, fe;
  logic [DW-1:0] rx_data;

  wire unused_tx_hi = ^tx_cfg[7:6];

  assign tx_max = 4'd5 + {2'b00, tx_cfg[1:0]};
  assign tx_w   = (in_nbits < tx_max) ? in_nbits : tx_max;
  assign rx_n   = 4'd5 + {2'b00, rx_cfg[1:0]};

  always_comb begin
    frame  = '0;
    tx_par = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (4'(i) < tx_w) begin
        frame[i] = in_data[i];
        tx_par   = tx_par ^ in_data[i];
      end
    end
    pos = tx_w;
    if (tx_cfg[3]) begin
      frame[pos] = tx_cfg[5] | (tx_cfg[4] ? tx_par : ~tx_par);
      pos = pos + 4'd1;
    end
    frame[pos] = 1'b1;
    pos = pos + 4'd1;
    if (tx_cfg[2]) frame[pos] = 1'b1;
  end

  always_comb begin
    rx_data = '0;
    rx_x    = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (4'(i) < rx_n) begin
        rx_data[i] = frame[i];
        rx_x       = rx_x ^ frame[i];
      end
    end
    rx_x = rx_x ^ frame[rx_n];
    pe   = 1'b0;
    q    = rx_n;
    if (rx_cfg[3]) begin
      pe = rx_cfg[5] ? ~frame[rx_n] : (rx_cfg[4] ? rx_x : ~rx_x);
      q  = rx_n + 4'd1;
    end
    fe = ~frame[q] | (rx_cfg[2] & ~frame[q + 4'd1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_status <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_status <= {fe, pe, rx_cfg, rx_data};
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_status_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_status));
  p_cfg_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_status[15:8] == $past(rx_cfg));
  p_no_pe_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_status[11]) |-> !out_status[16]);
  p_upper_data_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_status[7:0] >> (4'd5 + {2'b00, out_status[9:8]})) == 8'd0));
endmodule

// File: tb/frame_parity_xcheck_bench.sv
module frame_parity_xcheck_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic [3:0]  in_nbits = '0;
  logic [7:0]  tx_cfg = '0;
  logic [7:0]  rx_cfg = '0;
  logic        out_valid;
  logic [17:0] out_status;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct packed {
    logic [17:0] st;
    logic [31:0] tag;
  } exp_t;
  exp_t exq[$];

  always #2 clk = ~clk;

  frame_parity_xcheck u_frame_parity_xcheck (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_nbits(in_nbits), .tx_cfg(tx_cfg), .rx_cfg(rx_cfg),
    .out_valid(out_valid), .out_status(out_status)
  );

  function automatic logic [17:0] model(input int d, input int nb, input int tx, input int rx);
    int w, n, m, pk, x, pe, fe;
    w  = (nb < 5 + (tx & 3)) ? nb : 5 + (tx & 3);
    pk = d & ((1 << w) - 1);
    n  = w;
    if ((tx & 8) != 0) begin
      x = $countones(pk) % 2;
      if ((tx & 32) != 0) pk = pk | (1 << n);
      else if ((tx & 16) != 0) pk = pk | (x << n);
      else pk = pk | ((1 - x) << n);
      n++;
    end
    pk = pk | (1 << n);
    n++;
    if ((tx & 4) != 0) pk = pk | (1 << n);
    m  = 5 + (rx & 3);
    x  = $countones(pk & ((1 << (m + 1)) - 1)) % 2;
    pe = 0;
    if ((rx & 8) != 0) begin
      if ((rx & 32) != 0) pe = ((pk >> m) & 1) == 0 ? 1 : 0;
      else if ((rx & 16) != 0) pe = (x != 0) ? 1 : 0;
      else pe = (x != 1) ? 1 : 0;
      m++;
    end
    fe = ((pk >> m) & 1) == 0 ? 1 : 0;
    if ((rx & 4) != 0 && ((pk >> (m + 1)) & 1) == 0) fe = 1;
    return {fe[0], pe[0], rx[7:0], 8'(pk & ((1 << (5 + (rx & 3))) - 1))};
  endfunction

  task automatic send(input int d, input int nb, input int tx, input int rx,
                      input logic [17:0] ex, input logic [31:0] tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d[7:0];
    in_nbits = nb[3:0];
    tx_cfg   = tx[7:0];
    rx_cfg   = rx[7:0];
    exq.push_back('{st: ex, tag: tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  logic [17:0] last_st = '0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        checks++;
        if (exq.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected out_valid, status=%05h expected no output", out_status);
        end else begin
          exp_t e;
          e = exq.pop_front();
          if (out_status !== e.st) begin
            errors++;
            $display("FAIL %0s: status=%05h expected %05h", e.tag, out_status, e.st);
          end
        end
        last_st = out_status;
      end else begin
        checks++;
        if (out_status !== last_st) begin
          errors++;
          $display("FAIL R2: status moved without valid, status=%05h expected %05h", out_status, last_st);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, pending=%0d expected 0", exq.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_status !== 18'd0) begin
      errors++;
      $display("FAIL R1: valid=%b status=%05h expected 0 00000", out_valid, out_status);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R10: matching 8N1, no flags
    send(8'hA5, 8, 8'h03, 8'h03, 18'h003A5, "R10");
    // R4: even parity both sides, popcount 4 -> no error
    send(8'hA5, 8, 8'h1B, 8'h1B, 18'h01BA5, "R4");
    // R7: even sent, odd expected -> parity error
    send(8'hA5, 8, 8'h1B, 8'h0B, 18'h10BA5, "R7");
    // R9: 5N1 read as 8E2 -> framing error only
    send(8'h1F, 8, 8'h00, 8'h1F, 18'h21F3F, "R9");
    // R9 + R7 in the same word: 5N1 read as 8O2
    send(8'h1F, 8, 8'h00, 8'h0F, 18'h30F3F, "R9");
    // R3: requested 4 bits under 8-bit code, upper bits zero
    send(8'hFF, 4, 8'h03, 8'h03, model(8'hFF, 4, 8'h03, 8'h03), "R3");
    // R5: stick parity then two stops read as 8N2 -> ok
    send(8'h00, 8, 8'h2F, 8'h07, model(8'h00, 8, 8'h2F, 8'h07), "R5");
    // R8: parity off on receive, 7-bit, bits 7:6 set in cfg
    send(8'hFF, 8, 8'hC2, 8'hC2, 18'h0C27F, "R8");
    // R6: 5-bit receive of full byte
    send(8'hFF, 8, 8'h03, 8'h00, model(8'hFF, 8, 8'h03, 8'h00), "R6");
    idle(4);
    for (int tx = 0; tx < 64; tx++) begin
      for (int r = 0; r < 64; r++) begin
        int rx, d, nb;
        rx = r | ((tx & 3) << 6);
        d  = (tx * 37 + r * 11 + 5) & 255;
        nb = (tx + r) % 10;
        send(d, nb, tx, rx, model(d, nb, tx, rx), "R7");
      end
      if (tx % 16 == 15) idle(2);
    end
    idle(4);
    finished = 1;
    if (exq.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R2: %0d results missing, expected 0", exq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule